// File: doc/BRIEF.md
# Precise Exception Arbiter for a Five-Stage Pipeline

This block sits beside an in-order pipeline and collects the exception requests raised by each stage. A stage that sees a fault presents a cause code, the PC of its instruction and a flag saying whether that instruction occupies a branch delay slot. Every cycle the arbiter picks at most one of these requests to turn into a trap, so that exceptions remain precise.

The choice is made by program order, not by cause. The stage nearest to commit holds the oldest instruction, and that instruction's fault wins over any fault further up the pipe. The arbiter then produces a one-cycle trap pulse together with the chosen cause, the return PC and a delay-slot indicator. It also drives a flush mask that kills the faulting instruction and everything younger. Instructions older than the faulting one keep running and retire normally.

When the faulting instruction sits in a delay slot, the return PC is moved back one instruction to the branch, so that execution restarts at the branch. The trap registers and the pipeline datapath live outside this block.

Top module: `trap_select_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, the trap pulse, the flush mask, the cause, the return PC and the delay-slot indicator are all zero.
- R2: A stage's request counts only when both its valid bit and its request bit are high. A request from a stage whose valid bit is low never produces a trap and never affects the outputs.
- R3: Stage index 4 (commit) is the oldest and index 0 (fetch) the youngest. When several stages request at once, the request with the highest index is reported, whatever the cause values are.
- R4: The trap pulse is registered. It goes high in the cycle after a counted request is sampled and stays high for exactly one cycle.
- R5: During the cycle in which the trap pulse is high, all requests are ignored, so no trap follows in the next cycle.
- R6: With the pulse, the cause output equals the selected stage's cause code. When the selected stage's delay-slot flag is 0, the return PC equals that stage's PC and the delay-slot indicator is 0.
- R7: When the selected stage's delay-slot flag is 1, the return PC equals that stage's PC minus 4 (modulo 2^32) and the delay-slot indicator is 1.
- R8: With the pulse, flush mask bit i is 1 exactly for i less than or equal to the selected index. Bit 0 is fetch and bit 4 is commit. In any cycle without the pulse, the mask is all zero.
- R9: Between traps, the cause, return PC and delay-slot indicator keep the values of the most recent trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_valid | input | 5 | Per-stage valid bit; low means the stage holds a bubble |
| stg_req | input | 5 | Per-stage exception request |
| stg_slot | input | 5 | Per-stage delay-slot flag |
| stg_cause | input | 25 | Cause code per stage, 5 bits each, stage i at bits [5i+4:5i] |
| stg_pc | input | 160 | Instruction PC per stage, 32 bits each, stage i at bits [32i+31:32i] |
| trap_take | output | 1 | One-cycle trap pulse |
| trap_cause | output | 5 | Cause of the reported exception |
| trap_epc | output | 32 | Return PC of the reported exception |
| trap_in_slot | output | 1 | Reported instruction was in a delay slot |
| flush_mask | output | 5 | Kill mask for the selected stage and all younger stages |

## Verification
The hardest situation to reach is a new request arriving during the single cycle in which the pulse is high, since that cycle exists only right after a trap. The bench reaches it on every trap by driving all five stages valid and requesting in exactly that cycle. It then confirms that no second pulse follows and that the held cause and return PC stay unchanged. Around this, the bench sweeps all 1024 combinations of valid and request bits, with the delay-slot flags varying from one combination to the next. Cause codes are chosen to grow toward the younger stages, so a cause-ordered arbiter would pick a different stage than the program-ordered one.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;
   localparam int unsigned STAGE_CNT_DFLT  = 5;
   localparam int unsigned CAUSE_W_DFLT    = 5;
   localparam int unsigned ADDR_W_DFLT     = 32;
   localparam int unsigned INSN_BYTES_DFLT = 4;
endpackage

// File: rtl/trap_pick.sv
// Oldest-first selection: highest index wins.
module trap_pick #(
   parameter int unsigned N = trap_sel_pkg::STAGE_CNT_DFLT
) (
   input  logic [N-1:0] live,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] older;   // older[i]: some live request at index >= i
   assign older[N] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign older[i] = older[i+1] | live[i];
      assign grant[i] = live[i] & ~older[i+1];
   end

   assign any = older[0];
endmodule

// File: rtl/trap_route.sv
// AND-OR steering of the granted stage's payload, with optional delay-slot fix.
module trap_route #(
   parameter int unsigned N          = trap_sel_pkg::STAGE_CNT_DFLT,
   parameter int unsigned CAUSE_W    = trap_sel_pkg::CAUSE_W_DFLT,
   parameter int unsigned ADDR_W     = trap_sel_pkg::ADDR_W_DFLT,
   parameter int unsigned INSN_BYTES = trap_sel_pkg::INSN_BYTES_DFLT,
   parameter bit          SLOT_FIX   = 1'b1
) (
   input  logic [N-1:0]         grant,
   input  logic [N*CAUSE_W-1:0] cause_flat,
   input  logic [N*ADDR_W-1:0]  pc_flat,
   input  logic [N-1:0]         slot,
   output logic [CAUSE_W-1:0]   sel_cause,
   output logic [ADDR_W-1:0]    sel_epc,
   output logic                 sel_slot
);
   logic [CAUSE_W-1:0] cause_term [N];
   logic [ADDR_W-1:0]  pc_term    [N];
   logic [ADDR_W-1:0]  sel_pc;

   for (genvar i = 0; i < N; i++) begin : g_term
      assign cause_term[i] = cause_flat[i*CAUSE_W +: CAUSE_W] & {CAUSE_W{grant[i]}};
      assign pc_term[i]    = pc_flat[i*ADDR_W +: ADDR_W]      & {ADDR_W{grant[i]}};
   end

   always_comb begin
      sel_cause = '0;
      sel_pc    = '0;
      for (int i = 0; i < N; i++) begin
         sel_cause = sel_cause | cause_term[i];
         sel_pc    = sel_pc    | pc_term[i];
      end
   end

   assign sel_slot = |(slot & grant);

   if (SLOT_FIX) begin : g_fix
      assign sel_epc = sel_slot ? (sel_pc - ADDR_W'(INSN_BYTES)) : sel_pc;
   end else begin : g_nofix
      assign sel_epc = sel_pc;
   end
endmodule

// File: rtl/trap_flush.sv
// Kill mask: the granted stage and every younger (lower-index) stage.
module trap_flush #(
   parameter int unsigned N = trap_sel_pkg::STAGE_CNT_DFLT
) (
   input  logic [N-1:0] grant,
   output logic [N-1:0] mask
);
   logic [N:0] at_or_above;
   assign at_or_above[N] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_mask
      assign at_or_above[i] = at_or_above[i+1] | grant[i];
      assign mask[i]        = at_or_above[i];
   end
endmodule

// File: rtl/trap_select_unit.sv
module trap_select_unit #(
   parameter int unsigned N          = trap_sel_pkg::STAGE_CNT_DFLT,
   parameter int unsigned CAUSE_W    = trap_sel_pkg::CAUSE_W_DFLT,
   parameter int unsigned ADDR_W     = trap_sel_pkg::ADDR_W_DFLT,
   parameter int unsigned INSN_BYTES = trap_sel_pkg::INSN_BYTES_DFLT,
   parameter bit          SLOT_FIX   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         stg_valid,
   input  logic [N-1:0]         stg_req,
   input  logic [N-1:0]         stg_slot,
   input  logic [N*CAUSE_W-1:0] stg_cause,
   input  logic [N*ADDR_W-1:0]  stg_pc,
   output logic                 trap_take,
   output logic [CAUSE_W-1:0]   trap_cause,
   output logic [ADDR_W-1:0]    trap_epc,
   output logic                 trap_in_slot,
   output logic [N-1:0]         flush_mask
);
   if (N < 2)                  begin : g_bad_n     $error("N must be at least 2");          end
   if (CAUSE_W < 1)            begin : g_bad_cause $error("CAUSE_W must be positive");     end
   if (ADDR_W < 8)             begin : g_bad_addr  $error("ADDR_W too small");             end
   if (INSN_BYTES == 0 || INSN_BYTES >= (1 << 8))
                               begin : g_bad_insn  $error("INSN_BYTES out of range");      end

   logic [N-1:0]       live;
   logic [N-1:0]       grant;
   logic               any_live;
   logic [CAUSE_W-1:0] sel_cause;
   logic [ADDR_W-1:0]  sel_epc;
   logic               sel_slot;
   logic [N-1:0]       kill_mask;

   // The trap pulse doubles as the one-cycle redirect hold-off.
   assign live = stg_valid & stg_req & {N{~trap_take}};

   trap_pick #(.N(N)) u_pick (
      .live  (live),
      .grant (grant),
      .any   (any_live)
   );

   trap_route #(
      .N(N), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W),
      .INSN_BYTES(INSN_BYTES), .SLOT_FIX(SLOT_FIX)
   ) u_route (
      .grant      (grant),
      .cause_flat (stg_cause),
      .pc_flat    (stg_pc),
      .slot       (stg_slot),
      .sel_cause  (sel_cause),
      .sel_epc    (sel_epc),
      .sel_slot   (sel_slot)
   );

   trap_flush #(.N(N)) u_flush (
      .grant (grant),
      .mask  (kill_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_take    <= 1'b0;
         trap_cause   <= '0;
         trap_epc     <= '0;
         trap_in_slot <= 1'b0;
         flush_mask   <= '0;
      end else begin
         trap_take  <= any_live;
         flush_mask <= any_live ? kill_mask : '0;
         if (any_live) begin
            trap_cause   <= sel_cause;
            trap_epc     <= sel_epc;
            trap_in_slot <= sel_slot;
         end
      end
   end

   AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> !trap_take);                                              // R5
   AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |-> $past(|(stg_valid & stg_req)));                           // R2
   AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_take |-> (flush_mask == '0));                                     // R8
   AST_FLUSH_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |-> (flush_mask[0] && ((flush_mask & N'(flush_mask + 1'b1)) == '0))); // R8
   AST_NO_OLDER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |-> (($past(stg_valid & stg_req) & ~flush_mask) == '0));      // R3
   AST_HOLD_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_take |-> ($stable(trap_epc) && $stable(trap_cause) && $stable(trap_in_slot))); // R9
endmodule

// File: tb/tb_trap_select_unit.sv
`timescale 1ns/1ps
module tb_trap_select_unit;
   localparam int N = 5;
   localparam int C = 5;
   localparam int A = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   stg_valid = '0, stg_req = '0, stg_slot = '0;
   logic [N*C-1:0] stg_cause = '0;
   logic [N*A-1:0] stg_pc = '0;
   logic           trap_take, trap_in_slot;
   logic [C-1:0]   trap_cause;
   logic [A-1:0]   trap_epc;
   logic [N-1:0]   flush_mask;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   trap_select_unit dut (
      .clk(clk), .rst_n(rst_n),
      .stg_valid(stg_valid), .stg_req(stg_req), .stg_slot(stg_slot),
      .stg_cause(stg_cause), .stg_pc(stg_pc),
      .trap_take(trap_take), .trap_cause(trap_cause), .trap_epc(trap_epc),
      .trap_in_slot(trap_in_slot), .flush_mask(flush_mask)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #1_000_000;
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [A-1:0] last_epc;
      logic [C-1:0] last_cause;
      logic         last_slot;
      last_epc = '0; last_cause = '0; last_slot = 1'b0;

      repeat (3) @(negedge clk);
      // R1: during reset
      chk(trap_take == 0 && flush_mask == 0, "R1 reset take/mask", {trap_take, flush_mask}, 0);
      chk(trap_epc == 0 && trap_cause == 0 && trap_in_slot == 0, "R1 reset payload", trap_epc, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(trap_take == 0 && flush_mask == 0 && trap_epc == 0, "R1 after reset", trap_epc, 0);

      for (int combo = 0; combo < 1024; combo++) begin
         logic [N-1:0] v, r, s, m;
         int sel;
         logic [A-1:0] pcv, exp_epc;
         logic [C-1:0] exp_cause;
         v = combo[4:0];
         r = combo[9:5];
         s = {combo[2:0], combo[9:8]} ^ 5'b10101;
         stg_valid = v; stg_req = r; stg_slot = s;
         for (int i = 0; i < N; i++) begin
            // younger stages carry larger causes, so cause order disagrees with program order
            stg_cause[i*C +: C] = C'(combo + 24 - 4*i);
            stg_pc[i*A +: A]    = A'(32'h0000_1000 + combo*32 + (N-1-i)*4);
         end
         sel = -1;
         for (int i = 0; i < N; i++) if (v[i] && r[i]) sel = i;
         @(negedge clk);
         // R4 / R2: pulse one cycle after a counted request
         chk(trap_take == (sel >= 0), "R4 R2 pulse", trap_take, sel >= 0);
         if (sel >= 0) begin
            exp_cause = C'(combo + 24 - 4*sel);
            pcv       = A'(32'h0000_1000 + combo*32 + (N-1-sel)*4);
            exp_epc   = s[sel] ? pcv - 32'd4 : pcv;
            m         = N'((1 << (sel + 1)) - 1);
            chk(trap_cause == exp_cause, "R6 R3 cause", trap_cause, exp_cause);
            chk(trap_epc == exp_epc, s[sel] ? "R7 epc" : "R6 epc", trap_epc, exp_epc);
            chk(trap_in_slot == s[sel], "R7 slot flag", trap_in_slot, s[sel]);
            chk(flush_mask == m, "R8 R3 mask", flush_mask, m);
            last_epc = exp_epc; last_cause = exp_cause; last_slot = s[sel];
            // R5: every stage requests during the pulse cycle
            stg_valid = '1; stg_req = '1; stg_slot = '1;
            for (int i = 0; i < N; i++) stg_pc[i*A +: A] = 32'hDEAD_0000 + i;
            @(negedge clk);
            chk(trap_take == 0, "R5 hold-off pulse", trap_take, 0);
            chk(trap_epc == last_epc && trap_cause == last_cause, "R5 hold-off payload", trap_epc, last_epc);
         end else begin
            chk(flush_mask == 0, "R8 idle mask", flush_mask, 0);
            chk(trap_epc == last_epc && trap_cause == last_cause && trap_in_slot == last_slot,
                "R9 hold", trap_epc, last_epc);
         end
         stg_valid = '0; stg_req = '0;
      end

      // R7 wrap: commit at PC 0 in a delay slot, fetch also requesting
      stg_valid = 5'b10001; stg_req = 5'b10001; stg_slot = 5'b10000;
      stg_pc = '0; stg_cause[4*C +: C] = 5'd3; stg_cause[0 +: C] = 5'd30;
      @(negedge clk);
      chk(trap_epc == 32'hFFFF_FFFC, "R7 wrap epc", trap_epc, 32'hFFFF_FFFC);
      chk(trap_cause == 5'd3 && flush_mask == 5'b11111, "R3 commit wins", trap_cause, 3);
      stg_valid = '0; stg_req = '0;
      repeat (2) @(negedge clk);
      chk(trap_epc == 32'hFFFF_FFFC && trap_in_slot == 1, "R9 hold after wrap", trap_epc, 32'hFFFF_FFFC);
      summary();
   end
endmodule